// File: doc/BRIEF.md
# Power-Down Wake Controller

This block sequences a small controller system into and out of a full power-down state. Software first picks which external pins may wake the system and whether the wake should restart the system from its reset state or resume quickly with everything held. It then unlocks the protected control register with a key write and sets the power-down request bit. After two further instruction slots the block stops the system clock and freezes the output pins.

While the system is down, only a qualified low pulse on a selected wake pin or a hardware reset can end the state. Instruction strobes, register writes and timer ticks are all ignored. The pins are synchronised and sampled on an always-running sample clock. A pulse counts only if the pin was seen high during power-down, then falls, then stays low for a minimum number of sample cycles.

A qualified wake starts a timed sequence counted in timer ticks: regulator settling, then clock lock, then flash ready. A fast wake then releases the clock and keeps the pins held until software releases them. A reset-style wake instead runs a further reset phase, returns the configuration to its defaults, releases the pins, and sets a sticky flag that only a hardware reset or an explicit software clear removes.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After hardware reset, clk_stop, pin_hold and wake_rst_req are 0, the control register (address 0) reads 0x00, and the key register (address 1) reads 0x00.
- R2: Control register bit 0 requests power-down. The request is accepted only when the write directly follows a write of 0xA5 to address 1, and every write to address 0 uses up that unlock. Reading address 1 returns the unlock state in bit 0. A request without a valid unlock is dropped, but the other fields of the same write still take effect.
- R3: After a request is accepted, clk_stop rises in the cycle after the second further cpu_step pulse, and pin_hold rises with it.
- R4: Wake source is set by control bit 1 (external-interrupt pin) and bit 2 (serial receive pin). Either pin or both may be enabled. A pulse on a pin that is not enabled has no effect, and with neither bit set only a hardware reset ends power-down.
- R5: A wake needs the synchronised pin to be seen high during power-down and then low for at least LOW_CYCLES consecutive sample cycles. Shorter pulses, and a pin that was already low at entry and never rose, do not wake.
- R6: While clk_stop is 1, register writes, cpu_step pulses and ticks that come before a qualified wake change nothing.
- R7: After a qualified wake, clk_stop stays 1 until exactly REG_TICKS+LOCK_TICKS+FLASH_TICKS ticks have arrived and falls on the last of them.
- R8: With control bit 3 at 0 (fast wake), wake_rst_req stays 0, the configuration is kept, and pin_hold stays 1 after the clock restarts until software writes 1 to control bit 5.
- R9: With control bit 3 at 1 (reset wake), wake_rst_req is 1 for RST_TICKS ticks after the flash phase, with clk_stop and pin_hold at 0. Afterwards bits 1 to 3 of the control register read 0.
- R10: A reset wake sets the wake flag (control bit 4). The flag survives the reset phase and writes of 0, and is cleared by writing 1 to bit 4 or by hardware reset.
- R11: Hardware reset during power-down returns the block to running: clk_stop and pin_hold go to 0 and the control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sample clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 key |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| cpu_step | input | 1 | One-cycle pulse per executed instruction slot |
| pin_ext | input | 1 | External-interrupt wake pin, asynchronous, idles high |
| pin_rxd | input | 1 | Serial receive wake pin, asynchronous, idles high |
| tick | input | 1 | Stable timer tick for the wake delays |
| clk_stop | output | 1 | System clock gated off |
| pin_hold | output | 1 | Output pins frozen at their power-down values |
| wake_rst_req | output | 1 | System reset request during a reset-style wake |

## Verification
Several properties are checked on every cycle. The clock only stops right after an instruction slot. The clock gate and the reset request are never active together, and pins are released during the reset phase. A fast wake leaves the pins held when the clock restarts. The configuration never moves while the clock is stopped, and the flag is set when a reset phase ends. The bench scenarios cover what a per-cycle property cannot. These are the unlock key sequence, the exact tick count of each phase, the rejection of short pulses, unselected pins and pins that never rose, the readback of the configuration after each kind of wake, and hardware reset during power-down.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;

    localparam int          REG_W      = 8;
    localparam logic [7:0]  UNLOCK_KEY = 8'hA5;

    // control register bit positions
    localparam int B_REQ   = 0;
    localparam int B_EXT   = 1;
    localparam int B_RXD   = 2;
    localparam int B_RSTWK = 3;
    localparam int B_FLAG  = 4;
    localparam int B_HREL  = 5;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_ARM    = 3'd1,
        ST_DOWN   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_LOCK   = 3'd4,
        ST_FLASH  = 3'd5,
        ST_RSTSEQ = 3'd6
    } pd_state_e;

    typedef struct packed {
        logic reset_wake;
        logic rxd_en;
        logic ext_en;
    } pd_cfg_t;

    function automatic logic wake_hit(pd_cfg_t c, logic q_ext, logic q_rxd);
        return (c.ext_en & q_ext) | (c.rxd_en & q_rxd);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pd_pin_qual.sv
module pd_pin_qual #(
    parameter int LOW_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    input  logic enable,
    output logic qualified
);
    localparam int CW = $clog2(LOW_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] low_cnt;
    logic          armed;

    // two-flop synchroniser, idles high
    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], pin_async};
    end

    // a low run counts only after a high level has been seen while enabled
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            low_cnt <= '0;
            armed   <= 1'b0;
        end else if (sync_q[1]) begin
            low_cnt <= '0;
            armed   <= 1'b1;
        end else if (armed && (low_cnt != CW'(LOW_CYCLES))) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign qualified = (low_cnt == CW'(LOW_CYCLES));
endmodule

// File: rtl/pd_regs.sv
module pd_regs
    import pd_wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              cpu_live,
    input  logic              cpu_idle,
    input  logic              wake_rst,
    output pd_cfg_t           cfg,
    output logic              wake_flag,
    output logic              pd_go,
    output logic              hold_rel
);
    logic unlocked;
    logic wr_ctrl;
    logic wr_key;

    assign wr_ctrl = reg_wr && cpu_live && !reg_addr;
    assign wr_key  = reg_wr && cpu_live &&  reg_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            wake_flag <= 1'b0;
            unlocked  <= 1'b0;
        end else if (wake_rst) begin
            cfg       <= '0;
            wake_flag <= 1'b1;
            unlocked  <= 1'b0;
        end else if (wr_ctrl) begin
            cfg.ext_en     <= reg_wdata[B_EXT];
            cfg.rxd_en     <= reg_wdata[B_RXD];
            cfg.reset_wake <= reg_wdata[B_RSTWK];
            if (reg_wdata[B_FLAG]) wake_flag <= 1'b0;
            unlocked <= 1'b0;
        end else if (wr_key) begin
            unlocked <= (reg_wdata == UNLOCK_KEY);
        end
    end

    assign pd_go    = wr_ctrl && cpu_idle && unlocked && reg_wdata[B_REQ];
    assign hold_rel = wr_ctrl && cpu_idle && reg_wdata[B_HREL];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata[0] = unlocked;
        end else begin
            reg_rdata[B_EXT]   = cfg.ext_en;
            reg_rdata[B_RXD]   = cfg.rxd_en;
            reg_rdata[B_RSTWK] = cfg.reset_wake;
            reg_rdata[B_FLAG]  = wake_flag;
        end
    end
endmodule

// File: rtl/pd_seq.sv
module pd_seq
    import pd_wake_pkg::*;
#(
    parameter int REG_TICKS   = 150,
    parameter int LOCK_TICKS  = 200,
    parameter int FLASH_TICKS = 5,
    parameter int RST_TICKS   = 375
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cpu_step,
    input  logic      tick,
    input  logic      pd_go,
    input  logic      hold_rel,
    input  logic      wake_now,
    input  logic      reset_wake,
    output pd_state_e state,
    output logic      clk_stop,
    output logic      pin_hold,
    output logic      wake_rst_req
);
    localparam int MAXT = max2(max2(REG_TICKS, LOCK_TICKS), max2(FLASH_TICKS, RST_TICKS));
    localparam int TW   = $clog2(MAXT + 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] limit;
    logic          step_seen;
    logic          phase_end;

    always_comb begin
        case (state)
            ST_SETTLE: limit = TW'(REG_TICKS);
            ST_LOCK:   limit = TW'(LOCK_TICKS);
            ST_FLASH:  limit = TW'(FLASH_TICKS);
            ST_RSTSEQ: limit = TW'(RST_TICKS);
            default:   limit = TW'(1);
        endcase
    end

    assign phase_end = tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            cnt       <= '0;
            step_seen <= 1'b0;
            pin_hold  <= 1'b0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (hold_rel) pin_hold <= 1'b0;
                    if (pd_go) begin
                        state     <= ST_ARM;
                        step_seen <= 1'b0;
                    end
                end
                ST_ARM: begin
                    if (cpu_step) begin
                        if (step_seen) begin
                            state    <= ST_DOWN;
                            pin_hold <= 1'b1;
                        end else begin
                            step_seen <= 1'b1;
                        end
                    end
                end
                ST_DOWN: begin
                    cnt <= '0;
                    if (wake_now) state <= ST_SETTLE;
                end
                default: begin
                    if (phase_end) begin
                        cnt <= '0;
                        case (state)
                            ST_SETTLE: state <= ST_LOCK;
                            ST_LOCK:   state <= ST_FLASH;
                            ST_FLASH: begin
                                if (reset_wake) begin
                                    state    <= ST_RSTSEQ;
                                    pin_hold <= 1'b0;
                                end else begin
                                    state <= ST_RUN;
                                end
                            end
                            default:   state <= ST_RUN;
                        endcase
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign clk_stop     = (state == ST_DOWN) || (state == ST_SETTLE) ||
                          (state == ST_LOCK) || (state == ST_FLASH);
    assign wake_rst_req = (state == ST_RSTSEQ);
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
    import pd_wake_pkg::*;
#(
    parameter int LOW_CYCLES  = 10,
    parameter int REG_TICKS   = 150,
    parameter int LOCK_TICKS  = 200,
    parameter int FLASH_TICKS = 5,
    parameter int RST_TICKS   = 375
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        cpu_step,
    input  logic        pin_ext,
    input  logic        pin_rxd,
    input  logic        tick,
    output logic        clk_stop,
    output logic        pin_hold,
    output logic        wake_rst_req
);
    localparam int NPIN = 2;

    pd_state_e       state;
    pd_cfg_t         cfg;
    logic            wake_flag;
    logic            pd_go;
    logic            hold_rel;
    logic            wake_now;
    logic            in_down;
    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] qual;

    assign pins    = {pin_rxd, pin_ext};
    assign in_down = (state == ST_DOWN);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pd_pin_qual #(.LOW_CYCLES(LOW_CYCLES)) u_qual (
            .clk       (clk),
            .rst       (rst),
            .pin_async (pins[i]),
            .enable    (in_down),
            .qualified (qual[i])
        );
    end

    assign wake_now = wake_hit(cfg, qual[0], qual[1]);

    pd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_live  ((state == ST_RUN) || (state == ST_ARM)),
        .cpu_idle  (state == ST_RUN),
        .wake_rst  (wake_rst_req),
        .cfg       (cfg),
        .wake_flag (wake_flag),
        .pd_go     (pd_go),
        .hold_rel  (hold_rel)
    );

    pd_seq #(
        .REG_TICKS   (REG_TICKS),
        .LOCK_TICKS  (LOCK_TICKS),
        .FLASH_TICKS (FLASH_TICKS),
        .RST_TICKS   (RST_TICKS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cpu_step     (cpu_step),
        .tick         (tick),
        .pd_go        (pd_go),
        .hold_rel     (hold_rel),
        .wake_now     (wake_now),
        .reset_wake   (cfg.reset_wake),
        .state        (state),
        .clk_stop     (clk_stop),
        .pin_hold     (pin_hold),
        .wake_rst_req (wake_rst_req)
    );
endmodule

// File: rtl/pd_wake_checker.sv
module pd_wake_checker
    import pd_wake_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    cpu_step,
    input logic    clk_stop,
    input logic    pin_hold,
    input logic    wake_rst_req,
    input logic    wake_flag,
    input pd_cfg_t cfg
);
    // clock gate rises only right after an instruction slot
    assert_stop_after_step_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_stop) |-> $past(cpu_step));

    // reset phase runs with the clock on and the pins released
    assert_rstseq_released_R9: assert property (@(posedge clk) disable iff (rst)
        wake_rst_req |-> (!clk_stop && !pin_hold));

    assert_gate_rst_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({clk_stop, wake_rst_req}));

    // fast wake restarts the clock with the pins still frozen
    assert_fast_wake_holds_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(clk_stop) && !wake_rst_req) |-> pin_hold);

    // configuration is frozen while the clock is stopped
    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (clk_stop && $past(clk_stop)) |-> $stable(cfg));

    // flag is set once the reset phase ends
    assert_flag_after_rstseq_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_rst_req) |-> wake_flag);
endmodule

bind pd_wake_ctrl pd_wake_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_step     (cpu_step),
    .clk_stop     (clk_stop),
    .pin_hold     (pin_hold),
    .wake_rst_req (wake_rst_req),
    .wake_flag    (wake_flag),
    .cfg          (cfg)
);

// File: tb/tb_pd_wake_ctrl.sv
module tb_pd_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LOWC  = 8;
    localparam int T_REG = 3;
    localparam int T_PLL = 4;
    localparam int T_FL  = 2;
    localparam int T_RST = 5;
    localparam int T_WAKE = T_REG + T_PLL + T_FL;
    localparam logic [7:0] KEY = 8'hA5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cpu_step = 1'b0;
    logic       pin_ext = 1'b1;
    logic       pin_rxd = 1'b1;
    logic       tick = 1'b0;
    logic       clk_stop;
    logic       pin_hold;
    logic       wake_rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pd_wake_ctrl #(
        .LOW_CYCLES (LOWC),
        .REG_TICKS  (T_REG),
        .LOCK_TICKS (T_PLL),
        .FLASH_TICKS(T_FL),
        .RST_TICKS  (T_RST)
    ) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_step(cpu_step),
        .pin_ext(pin_ext), .pin_rxd(pin_rxd), .tick(tick),
        .clk_stop(clk_stop), .pin_hold(pin_hold), .wake_rst_req(wake_rst_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step();
        @(negedge clk); cpu_step = 1'b1;
        @(negedge clk); cpu_step = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        cyc(1);
    endtask

    task automatic pulse(input bit on_rxd, input int len);
        @(negedge clk);
        if (on_rxd) pin_rxd = 1'b0; else pin_ext = 1'b0;
        cyc(len);
        if (on_rxd) pin_rxd = 1'b1; else pin_ext = 1'b1;
        cyc(4);
    endtask

    task automatic enter_pd(input logic [7:0] cfgb);
        wr(1'b1, KEY);
        wr(1'b0, cfgb | 8'h01);
        step();
        chk("R3 one step: clk_stop", {7'b0, clk_stop}, 8'h00);
        step();
        chk("R3 two steps: clk_stop", {7'b0, clk_stop}, 8'h01);
        chk("R3 two steps: pin_hold", {7'b0, pin_hold}, 8'h01);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 clk_stop", {7'b0, clk_stop}, 8'h00);
        chk("R1 pin_hold", {7'b0, pin_hold}, 8'h00);
        chk("R1 wake_rst_req", {7'b0, wake_rst_req}, 8'h00);
        rd(1'b0, d); chk("R1 ctrl", d, 8'h00);
        rd(1'b1, d); chk("R1 key", d, 8'h00);
    endtask

    task automatic t_protect();
        logic [7:0] d;
        wr(1'b0, 8'h03);
        step(); step(); step();
        chk("R2 no key: clk_stop", {7'b0, clk_stop}, 8'h00);
        rd(1'b0, d); chk("R2 fields kept", d, 8'h02);
        wr(1'b1, KEY);
        rd(1'b1, d); chk("R2 unlocked", d, 8'h01);
        wr(1'b0, 8'h02);
        rd(1'b1, d); chk("R2 unlock consumed", d, 8'h00);
        wr(1'b0, 8'h03);
        step(); step(); step();
        chk("R2 consumed key: clk_stop", {7'b0, clk_stop}, 8'h00);
        wr(1'b1, 8'h5A);
        rd(1'b1, d); chk("R2 wrong key", d, 8'h00);
    endtask

    task automatic t_fast_ext();
        logic [7:0] d;
        enter_pd(8'h02);
        wr(1'b0, 8'h0C);
        step(); step(); step();
        pulse(1'b1, LOWC + 6);
        pulse(1'b0, LOWC - 3);
        ticks(T_WAKE + 2);
        chk("R4 R5 R6 still down", {7'b0, clk_stop}, 8'h01);
        pulse(1'b0, LOWC + 6);
        ticks(T_WAKE - 1);
        chk("R7 before last tick", {7'b0, clk_stop}, 8'h01);
        ticks(1);
        chk("R7 after last tick", {7'b0, clk_stop}, 8'h00);
        chk("R8 no reset req", {7'b0, wake_rst_req}, 8'h00);
        chk("R8 pins held", {7'b0, pin_hold}, 8'h01);
        rd(1'b0, d); chk("R6 R8 cfg kept", d, 8'h02);
        step(); cyc(3);
        chk("R8 still held", {7'b0, pin_hold}, 8'h01);
        wr(1'b0, 8'h22);
        chk("R8 released", {7'b0, pin_hold}, 8'h00);
    endtask

    task automatic t_rxd_reset();
        logic [7:0] d;
        enter_pd(8'h0C);
        pulse(1'b1, LOWC + 6);
        ticks(T_WAKE);
        chk("R9 clk on", {7'b0, clk_stop}, 8'h00);
        chk("R9 reset req", {7'b0, wake_rst_req}, 8'h01);
        chk("R9 pins released", {7'b0, pin_hold}, 8'h00);
        ticks(T_RST - 1);
        chk("R9 reset req held", {7'b0, wake_rst_req}, 8'h01);
        ticks(1);
        chk("R9 reset req ends", {7'b0, wake_rst_req}, 8'h00);
        rd(1'b0, d); chk("R9 R10 ctrl after reset wake", d, 8'h10);
        wr(1'b0, 8'h00);
        rd(1'b0, d); chk("R10 flag survives write 0", d, 8'h10);
        wr(1'b0, 8'h10);
        rd(1'b0, d); chk("R10 flag cleared by write 1", d, 8'h00);
    endtask

    task automatic t_either();
        logic [7:0] d;
        pin_ext = 1'b0;
        enter_pd(8'h0E);
        cyc(LOWC + 10);
        ticks(T_WAKE + 1);
        chk("R5 low at entry ignored", {7'b0, clk_stop}, 8'h01);
        pin_ext = 1'b1;
        cyc(4);
        pulse(1'b1, LOWC + 6);
        ticks(T_WAKE);
        chk("R4 either via rxd", {7'b0, wake_rst_req}, 8'h01);
        ticks(T_RST);
        rd(1'b0, d); chk("R10 flag set", d, 8'h10);
    endtask

    task automatic t_hwreset();
        logic [7:0] d;
        enter_pd(8'h08);
        pulse(1'b0, LOWC + 6);
        pulse(1'b1, LOWC + 6);
        ticks(T_WAKE + 1);
        chk("R4 no source stays down", {7'b0, clk_stop}, 8'h01);
        @(negedge clk) rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R11 clk_stop", {7'b0, clk_stop}, 8'h00);
        chk("R11 pin_hold", {7'b0, pin_hold}, 8'h00);
        rd(1'b0, d); chk("R10 R11 ctrl cleared", d, 8'h00);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_protect();
        t_fast_ext();
        t_rxd_reset();
        t_either();
        t_hwreset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule